// File: doc/BRIEF.md
# Framed 24-Bit Serial Command Receiver

This block is the command front end of a multi-channel output controller. An external host drives a 3-wire serial link (serial clock, active-low chip select, data) far slower than the block's system clock. The block brings the three wires into the system clock domain and detects serial clock rising edges. It assembles 24-bit command words and, for every complete word, issues a one-cycle write strobe that carries a 16-bit code and a 4-bit channel address toward a 16-entry code memory held elsewhere.

A host may hold chip select low across several words, and each word produces its own write. Two control bits in every word choose the update mode and the sequencer clock source. Each bit is OR-combined with a dedicated mode pin, so a 1 from either side wins. A frame that ends part-way through a word leaves no trace. While the chip's reset initialization runs, an input marks the link as ignored.

Top module: `cmd_word_rx`

## Requirements
- R1: After reset, `wr_en` and `fmt_err` are 0, and the latched control bits are 0, so `immed_eff` equals `pin_immed` and `extclk_eff` equals `pin_extclk`.
- R2: A word is 24 bits sampled on serial clock rising edges, MSB first. Bits 23..8 are the code, bits 7..4 the address, bit 3 a reserved zero, bit 2 the mode bit, bit 1 the clock bit, and bit 0 a fill zero. The 24th rising edge causes exactly one `wr_en` pulse, one system clock wide, carrying that code and address.
- R3: Address value n (0..15) selects channel n; every address is written with its own code.
- R4: Several words sent back to back in one low chip-select frame each produce their own write, in order.
- R5: When chip select rises after a bit count that is not a multiple of 24, the partial word is dropped with no write, and the next frame starts counting from its first bit.
- R6: `immed_eff` is 1 when the mode bit (bit 2) of the last word was 1 or `pin_immed` is 1, and 0 otherwise.
- R7: `extclk_eff` is 1 when the clock bit (bit 1) of the last word was 1 or `pin_extclk` is 1. A later word with the bit at 0 clears the latched selection.
- R8: While `init_busy` is 1, serial activity produces no write and changes no latched state.
- R9: A word whose reserved bit or fill bit is 1 is still written, and it sets `fmt_err`. Only reset clears `fmt_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_busy | input | 1 | High while reset initialization runs; serial input is ignored |
| ser_clk | input | 1 | Asynchronous serial clock |
| ser_csn | input | 1 | Asynchronous active-low frame select |
| ser_dat | input | 1 | Asynchronous serial data |
| pin_immed | input | 1 | External immediate-update request |
| pin_extclk | input | 1 | External sequencer-clock select |
| wr_en | output | 1 | One-cycle memory write strobe |
| wr_addr | output | 4 | Channel address of the write |
| wr_data | output | 16 | Code to be written |
| immed_eff | output | 1 | Effective immediate-update mode |
| extclk_eff | output | 1 | Effective external-clock select |
| fmt_err | output | 1 | Sticky flag for a malformed trailer bit |

## Verification
A bit counter that drifts by one shifts every field. Such a fault shows up at the first completed word as a wrong code or address on the write strobe, and as a missing or extra write at the end of a multi-word frame. A counter that is not cleared at frame end shows up one frame later: a truncated frame followed by a clean word yields a garbled or early write. Stale control latches appear on the merged mode outputs as soon as the next word completes. A wrong reset value of those latches appears on the merged mode outputs right after reset.

// File: rtl/cwr_pkg.sv
package cwr_pkg;
   // trailer layout below the address field, LSB at index 0
   localparam int TRAILER_W = 4;
   localparam int POS_FILL  = 0;
   localparam int POS_CLK   = 1;
   localparam int POS_MODE  = 2;
   localparam int POS_RESV  = 3;

   typedef struct packed {
      logic resv;
      logic mode;
      logic clk_sel;
      logic fill;
   } trailer_t;

   function automatic logic trailer_bad(input trailer_t t);
      return t.resv | t.fill;
   endfunction
endpackage

// File: rtl/cwr_sync.sv
module cwr_sync #(
   parameter int          W       = 3,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("cwr_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("cwr_sync: W must be at least 1");
   end

   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg <= {STAGES{RST_VAL}};
      end else begin
         stg <= {stg[STAGES-2:0], d};
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/cwr_shifter.sv
module cwr_shifter #(
   parameter int WORD_W = 24,
   localparam int CNT_W = $clog2(WORD_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_s,
   input  logic              csn_s,
   input  logic              dat_s,
   input  logic              busy,
   output logic              word_done,
   output logic [WORD_W-1:0] word
);
   if (WORD_W < 8) begin : g_bad_word
      $error("cwr_shifter: WORD_W too small");
   end

   localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

   logic             sclk_d;
   logic             rise;
   logic             active;
   logic [CNT_W-1:0] cnt;

   assign rise   = sclk_s & ~sclk_d;
   assign active = ~csn_s & ~busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d <= 1'b0;
      end else begin
         sclk_d <= sclk_s;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt       <= '0;
         word      <= '0;
         word_done <= 1'b0;
      end else begin
         word_done <= 1'b0;
         if (!active) begin
            cnt  <= '0;
            word <= '0;
         end else if (rise) begin
            word <= {word[WORD_W-2:0], dat_s};
            if (cnt == LAST) begin
               cnt       <= '0;
               word_done <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST); // R2
   AST_BUSY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (cnt == '0) && !word_done); // R8
   AST_NO_DONE_OUTSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      csn_s |=> !word_done); // R5
endmodule

// File: rtl/cwr_decode.sv
module cwr_decode
   import cwr_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 4,
   localparam int WORD_W = DATA_W + ADDR_W + TRAILER_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              word_done,
   input  logic [WORD_W-1:0] word,
   input  logic              pin_immed,
   input  logic              pin_extclk,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              immed_eff,
   output logic              extclk_eff,
   output logic              fmt_err
);
   trailer_t          trl;
   logic [ADDR_W-1:0] f_addr;
   logic [DATA_W-1:0] f_data;
   logic              mode_q;
   logic              clk_q;

   assign trl    = trailer_t'(word[TRAILER_W-1:0]);
   assign f_addr = word[TRAILER_W +: ADDR_W];
   assign f_data = word[TRAILER_W+ADDR_W +: DATA_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_en   <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
         mode_q  <= 1'b0;
         clk_q   <= 1'b0;
         fmt_err <= 1'b0;
      end else begin
         wr_en <= word_done;
         if (word_done) begin
            wr_addr <= f_addr;
            wr_data <= f_data;
            mode_q  <= trl.mode;
            clk_q   <= trl.clk_sel;
            if (trailer_bad(trl)) begin
               fmt_err <= 1'b1;
            end
         end
      end
   end

   assign immed_eff  = mode_q | pin_immed;
   assign extclk_eff = clk_q | pin_extclk;

   AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en); // R2
   AST_FMT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      fmt_err |=> fmt_err); // R9
   AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !word_done |=> $stable(mode_q) && $stable(clk_q)); // R7
endmodule

// File: rtl/cmd_word_rx.sv
module cmd_word_rx
   import cwr_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int ADDR_W      = 4,
   parameter int SYNC_STAGES = 2,
   localparam int WORD_W     = DATA_W + ADDR_W + TRAILER_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init_busy,
   input  logic              ser_clk,
   input  logic              ser_csn,
   input  logic              ser_dat,
   input  logic              pin_immed,
   input  logic              pin_extclk,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              immed_eff,
   output logic              extclk_eff,
   output logic              fmt_err
);
   if (DATA_W < 1 || ADDR_W < 1) begin : g_bad_fields
      $error("cmd_word_rx: field widths must be positive");
   end

   logic [2:0]        raw;
   logic [2:0]        syn;
   logic              done;
   logic [WORD_W-1:0] word;

   assign raw = {ser_clk, ser_csn, ser_dat};

   cwr_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
   );

   cwr_shifter #(.WORD_W(WORD_W)) u_shift (
      .clk(clk), .rst_n(rst_n),
      .sclk_s(syn[2]), .csn_s(syn[1]), .dat_s(syn[0]),
      .busy(init_busy),
      .word_done(done), .word(word)
   );

   cwr_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dec (
      .clk(clk), .rst_n(rst_n),
      .word_done(done), .word(word),
      .pin_immed(pin_immed), .pin_extclk(pin_extclk),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .immed_eff(immed_eff), .extclk_eff(extclk_eff), .fmt_err(fmt_err)
   );

   AST_BUSY_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(init_busy) |-> !wr_en); // R8
endmodule

// File: tb/cmd_word_rx_tb.sv
module cmd_word_rx_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        init_busy = 1'b0;
   logic        ser_clk = 1'b0;
   logic        ser_csn = 1'b1;
   logic        ser_dat = 1'b0;
   logic        pin_immed = 1'b0;
   logic        pin_extclk = 1'b0;
   logic        wr_en;
   logic [3:0]  wr_addr;
   logic [15:0] wr_data;
   logic        immed_eff;
   logic        extclk_eff;
   logic        fmt_err;

   int checks = 0;
   int errors = 0;
   int wr_cnt = 0;
   logic [15:0] cap_mem [16];
   logic [3:0]  last_addr;

   always #10 clk = ~clk;

   cmd_word_rx dut_i (
      .clk(clk), .rst_n(rst_n), .init_busy(init_busy),
      .ser_clk(ser_clk), .ser_csn(ser_csn), .ser_dat(ser_dat),
      .pin_immed(pin_immed), .pin_extclk(pin_extclk),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .immed_eff(immed_eff), .extclk_eff(extclk_eff), .fmt_err(fmt_err)
   );

   always @(posedge clk) begin
      if (wr_en) begin
         cap_mem[wr_addr] <= wr_data;
         last_addr        <= wr_addr;
         wr_cnt           <= wr_cnt + 1;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [23:0] mk(input logic [15:0] d, input logic [3:0] a,
                                      input logic resv, input logic m,
                                      input logic c, input logic fill);
      return {d, a, resv, m, c, fill};
   endfunction

   function automatic logic [15:0] code_for(input int a, input int salt);
      return 16'((a * 4099 + salt * 257) ^ 16'h5A5A);
   endfunction

   task automatic wclk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bits(input logic [23:0] w, input int nbits);
      for (int i = 23; i > 23 - nbits; i--) begin
         ser_dat = w[i];
         wclk(4);
         ser_clk = 1'b1;
         wclk(4);
         ser_clk = 1'b0;
      end
   endtask

   task automatic frame_open();
      ser_csn = 1'b0;
      wclk(4);
   endtask

   task automatic frame_close();
      wclk(4);
      ser_csn = 1'b1;
      wclk(10);
   endtask

   task automatic one_word(input logic [23:0] w);
      frame_open();
      send_bits(w, 24);
      frame_close();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int base;
      logic [15:0] d;
      wclk(5);
      rst_n = 1'b1;
      wclk(5);

      // R1: reset state
      check("R1 wr_en", int'(wr_en), 0);
      check("R1 fmt_err", int'(fmt_err), 0);
      check("R1 immed_eff", int'(immed_eff), 0);
      check("R1 extclk_eff", int'(extclk_eff), 0);
      pin_immed = 1'b1; pin_extclk = 1'b1;
      wclk(1);
      check("R1 immed pin only", int'(immed_eff), 1);
      check("R1 extclk pin only", int'(extclk_eff), 1);
      pin_immed = 1'b0; pin_extclk = 1'b0;

      // R2 R3: every address, one word per frame
      for (int a = 0; a < 16; a++) begin
         base = wr_cnt;
         one_word(mk(code_for(a, 0), 4'(a), 1'b0, 1'b0, 1'b0, 1'b0));
         check("R2 one strobe per word", wr_cnt - base, 1);
         check("R3 address", int'(last_addr), a);
      end
      for (int a = 0; a < 16; a++) begin
         check("R3 code at channel", int'(cap_mem[a]), int'(code_for(a, 0)));
      end

      // R4: three words in one frame
      base = wr_cnt;
      frame_open();
      send_bits(mk(code_for(2, 1), 4'd2, 0, 0, 0, 0), 24);
      send_bits(mk(code_for(14, 1), 4'd14, 0, 0, 0, 0), 24);
      send_bits(mk(code_for(7, 1), 4'd7, 0, 0, 0, 0), 24);
      frame_close();
      check("R4 writes in frame", wr_cnt - base, 3);
      check("R4 word 1", int'(cap_mem[2]), int'(code_for(2, 1)));
      check("R4 word 2", int'(cap_mem[14]), int'(code_for(14, 1)));
      check("R4 word 3", int'(cap_mem[7]), int'(code_for(7, 1)));
      check("R4 order", int'(last_addr), 7);

      // R5: truncated frames, then a clean word
      base = wr_cnt;
      frame_open();
      send_bits(mk(16'hFFFF, 4'd9, 0, 0, 0, 0), 10);
      frame_close();
      check("R5 partial dropped", wr_cnt - base, 0);
      frame_open();
      send_bits(mk(code_for(11, 2), 4'd11, 0, 0, 0, 0), 24);
      send_bits(mk(16'h1234, 4'd9, 0, 0, 0, 0), 13);
      frame_close();
      check("R5 full word then partial", wr_cnt - base, 1);
      check("R5 channel 9 untouched", int'(cap_mem[9]), int'(code_for(9, 0)));
      one_word(mk(code_for(9, 2), 4'd9, 0, 0, 0, 0));
      check("R5 restart count", int'(cap_mem[9]), int'(code_for(9, 2)));

      // R6 R7: control bits merged with pins
      for (int c = 0; c < 4; c++) begin
         for (int p = 0; p < 4; p++) begin
            pin_immed  = p[1];
            pin_extclk = p[0];
            one_word(mk(code_for(c, p), 4'(c), 1'b0, c[1], c[0], 1'b0));
            check("R6 immed merge", int'(immed_eff), int'(c[1] | p[1]));
            check("R7 extclk merge", int'(extclk_eff), int'(c[0] | p[0]));
         end
      end
      pin_immed = 1'b0; pin_extclk = 1'b0;
      one_word(mk(16'h0001, 4'd0, 0, 1, 1, 0));
      one_word(mk(16'h0002, 4'd0, 0, 0, 0, 0));
      check("R7 clock bit not repeated", int'(extclk_eff), 0);
      check("R6 mode bit cleared", int'(immed_eff), 0);

      // R8: ignored while init runs
      one_word(mk(16'h0003, 4'd1, 0, 1, 1, 0));
      base = wr_cnt;
      d = cap_mem[5];
      init_busy = 1'b1;
      one_word(mk(16'hBEEF, 4'd5, 0, 0, 0, 0));
      check("R8 no write when busy", wr_cnt - base, 0);
      check("R8 memory unchanged", int'(cap_mem[5]), int'(d));
      check("R8 mode latch kept", int'(immed_eff), 1);
      check("R8 clock latch kept", int'(extclk_eff), 1);
      init_busy = 1'b0;
      wclk(4);
      one_word(mk(16'hBEEF, 4'd5, 0, 0, 0, 0));
      check("R8 write after busy", int'(cap_mem[5]), 16'hBEEF);

      // R9: malformed trailer
      check("R9 flag clear", int'(fmt_err), 0);
      base = wr_cnt;
      one_word(mk(16'hA5C3, 4'd3, 1, 0, 0, 0));
      check("R9 written anyway", int'(cap_mem[3]), 16'hA5C3);
      check("R9 reserved sets flag", int'(fmt_err), 1);
      one_word(mk(16'h0F0F, 4'd4, 0, 0, 0, 0));
      check("R9 flag sticky", int'(fmt_err), 1);
      check("R9 write count", wr_cnt - base, 2);
      rst_n = 1'b0;
      wclk(3);
      rst_n = 1'b1;
      wclk(3);
      check("R9 cleared by reset", int'(fmt_err), 0);
      one_word(mk(16'h7777, 4'd6, 0, 0, 0, 1));
      check("R9 fill sets flag", int'(fmt_err), 1);
      check("R9 fill word written", int'(cap_mem[6]), 16'h7777);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule